// File: doc/BRIEF.md
# Priority Bus-Width Allocator

This block shares a test bus between cores that are waiting to be tested. When a request is accepted it captures, for every core, a waiting flag, the number of patterns still to apply, the present temperature code and the bus width that core needs. It also captures the bus limit and the width already taken. It then visits the waiting cores one per cycle, most urgent first. Urgency is remaining patterns divided by temperature, so a core with much work left that is also cold goes first. A core whose width fits into what is left of the bus is granted and its width is deducted. A core that does not fit is passed over, and the next core is tried.

The result is a grant vector and the updated width in use. A caller uses it to move the granted cores into testing. The caller returns widths freed by cores that have left testing by lowering the in-use value it presents before the next request.

Requests and results each use a valid/ready pair. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A result is offered with `res_valid` and stays unchanged until `res_ready` is seen high. While a result is held back, no new request is accepted.

Top module: `bw_alloc`

## Requirements
- R1: `req_ready` is high only when no pass is running and no result is pending. A request presented while `req_ready` is low is not taken and does not alter the pending result.
- R2: A core whose waiting bit is 0 in the accepted request is never granted, whatever its width.
- R3: Waiting cores are visited in decreasing order of remaining/temperature. The comparison uses cross products: a beats b when rem_a*temp_b > rem_b*temp_a. Equal ratios go to the lower core index.
- R4: A visited core is granted exactly when its required width is no more than the capacity left at its turn. A core that does not fit is skipped and the pass goes on to the next core.
- R5: The pass ends as soon as the capacity left reaches zero or no waiting core remains unvisited. Cores not yet visited at that point are not granted, even those needing zero width.
- R6: `new_in_use` equals the accepted in-use width plus the widths of all granted cores, and never exceeds the bus limit. If the in-use width is already at or above the limit, nothing is granted and `new_in_use` equals the in-use width.
- R7: Once `res_valid` is high, it stays high and `grant` and `new_in_use` stay unchanged until a cycle with `res_ready` high. After that cycle the block returns to idle.
- R8: After reset, `req_ready` is 1, `res_valid` is 0 and `grant` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| waiting | input | N_CORES | Per-core waiting flag |
| remaining | input | N_CORES*CNT_W | Per-core remaining pattern count |
| temp | input | N_CORES*TEMP_W | Per-core temperature code |
| need_width | input | N_CORES*WID_W | Per-core required bus width |
| bus_limit | input | WID_W | Total bus width limit |
| in_use | input | WID_W | Width already allocated |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken |
| grant | output | N_CORES | Cores granted in this pass |
| new_in_use | output | WID_W | Width in use after the pass |

## Verification
Some properties are checked on every cycle. The capacity register never grows during a pass, and capacity plus granted width stays constant. No grant lands on a core that was not waiting. The chosen core is always an unvisited candidate. A held result stays stable under back-pressure, and ready and a pending result never coincide. Only the directed scenarios can show other behaviours: the visiting order by ratio, including ties decided through cross products, skipping a core that is too wide and then granting a later one, an early stop on an exhausted bus, and the exact result values.

// File: rtl/bw_alloc_pkg.sv
package bw_alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } alloc_state_e;
endpackage

// File: rtl/bw_prio_pick.sv
// Combinational selection of the most urgent unvisited candidate.
// Urgency rem/temp compared via cross products; strict compare keeps
// the lower index on ties because the chain runs from index 0 upward.
module bw_prio_pick #(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 16,
  parameter int TEMP_W  = 8,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int PW     = CNT_W + TEMP_W
) (
  input  logic [N_CORES-1:0]             cand_i,
  input  logic [N_CORES-1:0][CNT_W-1:0]  rem_i,
  input  logic [N_CORES-1:0][TEMP_W-1:0] temp_i,
  output logic                           any_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic [IDX_W-1:0] best_idx [N_CORES];
  logic             best_val [N_CORES];

  for (genvar i = 0; i < N_CORES; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign best_val[0] = cand_i[0];
      assign best_idx[0] = '0;
    end else begin : g_next
      logic [PW-1:0] lhs, rhs;
      logic          beats;
      assign lhs   = PW'(rem_i[i]) * PW'(temp_i[best_idx[i-1]]);
      assign rhs   = PW'(rem_i[best_idx[i-1]]) * PW'(temp_i[i]);
      assign beats = cand_i[i] && (!best_val[i-1] || (lhs > rhs));
      assign best_val[i] = best_val[i-1] | cand_i[i];
      assign best_idx[i] = beats ? IDX_W'(i) : best_idx[i-1];
    end
  end

  assign any_o = best_val[N_CORES-1];
  assign idx_o = best_idx[N_CORES-1];

  always_comb begin
    if (any_o) begin
      p_pick_is_cand_r3: assert (cand_i[idx_o]);
    end
  end
endmodule

// File: rtl/bw_budget.sv
// Remaining-capacity register and granted-width accumulator.
module bw_budget #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WID_W-1:0] load_cap_i,
  input  logic             step_i,
  input  logic [WID_W-1:0] width_i,
  output logic             fit_o,
  output logic [WID_W-1:0] cap_o,
  output logic [WID_W-1:0] spent_o
);
  logic [WID_W-1:0] cap_q, spent_q;

  assign fit_o = (width_i <= cap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      spent_q <= '0;
    end else if (load_i) begin
      cap_q   <= load_cap_i;
      spent_q <= '0;
    end else if (step_i && fit_o) begin
      cap_q   <= cap_q - width_i;
      spent_q <= spent_q + width_i;
    end
  end

  assign cap_o   = cap_q;
  assign spent_o = spent_q;

  p_cap_nonincr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> cap_q <= $past(cap_q));

  p_conserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ({1'b0, cap_q} + {1'b0, spent_q}) ==
                $past({1'b0, cap_q} + {1'b0, spent_q}));
endmodule

// File: rtl/bw_alloc.sv
module bw_alloc
  import bw_alloc_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 16,
  parameter int TEMP_W  = 8,
  parameter int WID_W   = 8,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [N_CORES-1:0]              waiting,
  input  logic [N_CORES-1:0][CNT_W-1:0]   remaining,
  input  logic [N_CORES-1:0][TEMP_W-1:0]  temp,
  input  logic [N_CORES-1:0][WID_W-1:0]   need_width,
  input  logic [WID_W-1:0]                bus_limit,
  input  logic [WID_W-1:0]                in_use,
  output logic                            res_valid,
  input  logic                            res_ready,
  output logic [N_CORES-1:0]              grant,
  output logic [WID_W-1:0]                new_in_use
);
  alloc_state_e state_q;
  logic [N_CORES-1:0]             wait_q, cand_q, grant_q;
  logic [N_CORES-1:0][CNT_W-1:0]  rem_q;
  logic [N_CORES-1:0][TEMP_W-1:0] temp_q;
  logic [N_CORES-1:0][WID_W-1:0]  need_q;
  logic [WID_W-1:0]               used_q, limit_q;

  logic             any_pick;
  logic [IDX_W-1:0] pick_idx;
  logic             fit, step, load;
  logic [WID_W-1:0] cap, spent, load_cap;

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_DONE);
  assign load      = req_valid && req_ready;
  assign load_cap  = (bus_limit > in_use) ? (bus_limit - in_use) : '0;
  assign step      = (state_q == ST_SCAN) && any_pick && (cap != '0);

  bw_prio_pick #(.N_CORES(N_CORES), .CNT_W(CNT_W), .TEMP_W(TEMP_W)) u_pick (
    .cand_i (cand_q),
    .rem_i  (rem_q),
    .temp_i (temp_q),
    .any_o  (any_pick),
    .idx_o  (pick_idx)
  );

  bw_budget #(.WID_W(WID_W)) u_budget (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_cap_i (load_cap),
    .step_i     (step),
    .width_i    (need_q[pick_idx]),
    .fit_o      (fit),
    .cap_o      (cap),
    .spent_o    (spent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      cand_q  <= '0;
      grant_q <= '0;
      rem_q   <= '0;
      temp_q  <= '0;
      need_q  <= '0;
      used_q  <= '0;
      limit_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load) begin
          wait_q  <= waiting;
          cand_q  <= waiting;
          grant_q <= '0;
          rem_q   <= remaining;
          temp_q  <= temp;
          need_q  <= need_width;
          used_q  <= in_use;
          limit_q <= bus_limit;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (step) begin
            cand_q[pick_idx] <= 1'b0;
            if (fit) grant_q[pick_idx] <= 1'b1;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign grant      = res_valid ? grant_q : '0;
  assign new_in_use = used_q + spent;

  p_grant_waiting_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q & ~wait_q) == '0);

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(grant) && $stable(new_in_use));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && grant != '0) |-> new_in_use <= limit_q);
endmodule

// File: tb/tb_bw_alloc.sv
module tb_bw_alloc;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, res_ready = 1'b1;
  logic req_ready, res_valid;
  logic [N-1:0] waiting = '0;
  logic [N-1:0][15:0] remaining = '0;
  logic [N-1:0][7:0] temp = '0, need_width = '0;
  logic [7:0] bus_limit = '0, in_use = '0, new_in_use;
  logic [N-1:0] grant;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bw_alloc dut (.clk, .rst_n, .req_valid, .req_ready, .waiting, .remaining,
    .temp, .need_width, .bus_limit, .in_use, .res_valid, .res_ready,
    .grant, .new_in_use);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [N-1:0] w, input logic [N-1:0][15:0] r,
      input logic [N-1:0][7:0] t, input logic [N-1:0][7:0] nw,
      input logic [7:0] lim, input logic [7:0] used);
    waiting = w; remaining = r; temp = t; need_width = nw;
    bus_limit = lim; in_use = used;
  endtask

  task automatic wait_result(input string req);
    int cnt = 0;
    while (!res_valid && cnt < 40) begin @(negedge clk); cnt++; end
    if (!res_valid) chk({req, " timeout"}, 0, 1);
  endtask

  task automatic run_pass(input string req, input logic [N-1:0] eg, input int eu);
    @(negedge clk); req_valid = 1'b1;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    wait_result(req);
    chk({req, " grant"}, grant, eg);
    chk({req, " new_in_use"}, new_in_use, eu);
    @(posedge clk); @(negedge clk);
  endtask

  // R8
  task automatic t_reset();
    chk("R8 req_ready", req_ready, 1);
    chk("R8 res_valid", res_valid, 0);
    chk("R8 grant", grant, 0);
  endtask

  // R3 ratios 2,4,1,3 -> order 1,3,0,2; R4 skips 0 and 2
  task automatic t_order();
    load(4'b1111, {16'd300, 16'd50, 16'd200, 16'd100},
         {8'd100, 8'd50, 8'd50, 8'd50}, {8'd5, 8'd6, 8'd10, 8'd8}, 8'd20, 8'd0);
    run_pass("R3 R4 ratio order", 4'b1010, 15);
  endtask

  // R4 skip then continue
  task automatic t_skip();
    load(4'b1111, {16'd100, 16'd200, 16'd300, 16'd400},
         {8'd10, 8'd10, 8'd10, 8'd10}, {8'd3, 8'd7, 8'd4, 8'd12}, 8'd10, 8'd0);
    run_pass("R4 skip continue", 4'b1010, 7);
  endtask

  // R2 non-waiting core 1 excluded
  task automatic t_notwait();
    load(4'b0101, {16'd100, 16'd200, 16'd300, 16'd400},
         {8'd10, 8'd10, 8'd10, 8'd10}, {8'd3, 8'd7, 8'd4, 8'd12}, 8'd20, 8'd0);
    run_pass("R2 non-waiting", 4'b0101, 19);
  endtask

  // R5 capacity hits zero; zero-width cores left ungranted
  task automatic t_exhaust();
    load(4'b1111, {16'd100, 16'd200, 16'd300, 16'd400},
         {8'd10, 8'd10, 8'd10, 8'd10}, {8'd0, 8'd0, 8'd0, 8'd6}, 8'd10, 8'd4);
    run_pass("R5 early stop", 4'b0001, 10);
  endtask

  // R6 full or overfull bus
  task automatic t_full();
    load(4'b1111, {16'd1, 16'd1, 16'd1, 16'd1},
         {8'd1, 8'd1, 8'd1, 8'd1}, {8'd0, 8'd1, 8'd1, 8'd1}, 8'd8, 8'd8);
    run_pass("R6 bus full", 4'b0000, 8);
    in_use = 8'd9;
    run_pass("R6 bus overfull", 4'b0000, 9);
  endtask

  // R3 ties: equal values, and equal ratio via different products
  task automatic t_tie();
    load(4'b1111, {16'd50, 16'd50, 16'd50, 16'd50},
         {8'd10, 8'd10, 8'd10, 8'd10}, {8'd5, 8'd5, 8'd5, 8'd5}, 8'd5, 8'd0);
    run_pass("R3 tie equal", 4'b0001, 5);
    load(4'b1100, {16'd50, 16'd100, 16'd0, 16'd0},
         {8'd10, 8'd20, 8'd1, 8'd1}, {8'd5, 8'd5, 8'd5, 8'd5}, 8'd5, 8'd0);
    run_pass("R3 tie cross", 4'b0100, 5);
  endtask

  // R7 hold under back-pressure; R1 request ignored while busy
  task automatic t_backpressure();
    res_ready = 1'b0;
    load(4'b1111, {16'd300, 16'd50, 16'd200, 16'd100},
         {8'd100, 8'd50, 8'd50, 8'd50}, {8'd5, 8'd6, 8'd10, 8'd8}, 8'd20, 8'd0);
    @(negedge clk); req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 ready low while busy", req_ready, 0);
    load(4'b1111, {16'd1, 16'd1, 16'd1, 16'd1}, {8'd1, 8'd1, 8'd1, 8'd1},
         {8'd1, 8'd1, 8'd1, 8'd1}, 8'd40, 8'd0);
    @(negedge clk); @(negedge clk); req_valid = 1'b0;
    wait_result("R7");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 res_valid held", res_valid, 1);
      chk("R7 grant held", grant, 4'b1010);
      chk("R1 busy request ignored", new_in_use, 15);
      chk("R1 ready low on pending", req_ready, 0);
    end
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 released", res_valid, 0);
    chk("R1 ready back", req_ready, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_skip();
    t_notwait();
    t_exhaust();
    t_full();
    t_tie();
    t_backpressure();
    summary();
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule